// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block steers a multicycle datapath from a small microcode store. A microprogram counter selects one microword per cycle. Each word holds seven narrow fields: ALU function, first operand source, second operand source, register-file action, memory action, PC-update action and sequencing. A decoder turns the fields into the datapath control lines. The sequencing field chooses the next microaddress. It can take the next address in order, return to the fetch word at address 0, or jump through one of two small tables indexed by the 6-bit instruction opcode.

The first dispatch table runs after the shared decode word and picks the routine for the instruction class. The second table runs after the memory-address word and picks between the load routine and the store routine. The control lines depend only on the current microaddress. The opcode input is read only where a dispatch takes place.

Top module: `useq_ctrl`

## Requirements
- R1: While rst_n is sampled low at a rising edge, uaddr becomes 0 at that edge and stays 0.
- R2: A word whose sequencing field selects the next address (addresses 0, 3 and 6) moves uaddr to the current address plus one at the next edge.
- R3: At address 1 the next uaddr comes from the first dispatch table: opcode 6'b000000 goes to 6, 6'b000010 to 9, 6'b000100 to 8, and both 6'b100011 and 6'b101011 go to 2. Every other opcode goes to 0.
- R4: At address 2 the next uaddr comes from the second dispatch table: 6'b100011 goes to 3 and 6'b101011 goes to 5. Every other opcode goes to 0.
- R5: Addresses 4, 5, 7, 8 and 9, and any address above 9, return uaddr to 0 at the next edge whatever the opcode.
- R6: At address 0 the outputs are:
  - mem_rd=1, instr_load=1, addr_from_alu=0
  - pc_load=1, pc_sel=00
  - alu_fn=00 (add), alu_a_sel=0 (PC), alu_b_sel=01 (constant 4)
- R7: At address 1 the outputs are alu_fn=00, alu_a_sel=0 and alu_b_sel=11 (shifted offset). No strobe is active.
- R8: At address 2 the outputs are alu_fn=00, alu_a_sel=1 and alu_b_sel=10 (sign-extended offset).
- R9: Memory accesses by address:
  - Address 3 drives mem_rd=1 with addr_from_alu=1.
  - Address 5 drives mem_wr=1 with addr_from_alu=1.
  - mem_rd and mem_wr are never both 1.
- R10: Register writes by address:
  - Address 4 drives rf_we=1, rf_dst_rd=0 and wb_from_mem=1.
  - Address 7 drives rf_we=1, rf_dst_rd=1 and wb_from_mem=0.
- R11: Address 6 drives alu_fn=10 (function code), alu_a_sel=1 and alu_b_sel=00 (register B).
- R12: PC updates by address:
  - Address 8 drives alu_fn=01 (subtract), alu_a_sel=1, alu_b_sel=00, pc_load_if_zero=1 and pc_sel=01.
  - Address 9 drives pc_load=1 and pc_sel=10.
- R13: Any output field that the current word does not set is 0. This holds for every strobe and every select, and every output is 0 above address 9. Opcode changes outside addresses 1 and 2 change neither the outputs nor the next uaddr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 6 | Instruction opcode used by the dispatch tables |
| pc_load | output | 1 | Unconditional PC write |
| pc_load_if_zero | output | 1 | PC write qualified by the ALU zero flag |
| addr_from_alu | output | 1 | Memory address from the ALU result register (0: from PC) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| instr_load | output | 1 | Instruction register load |
| wb_from_mem | output | 1 | Register write data from the memory data register |
| pc_sel | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_fn | output | 2 | 00 add, 01 subtract, 10 function code |
| alu_b_sel | output | 2 | 00 B, 01 constant 4, 10 extended, 11 extended and shifted |
| alu_a_sel | output | 1 | 0 PC, 1 register A |
| rf_we | output | 1 | Register file write enable |
| rf_dst_rd | output | 1 | Destination from the rd field (0: rt field) |
| uaddr | output | 4 | Current microaddress |

## Verification
A wrong microaddress is visible on uaddr at the next rising edge. At the same time the decoded lines stop matching the word the bench expects for its own address model, so a bad dispatch entry or a wrong sequencing code is caught one cycle after the edge that took it. A wrong field inside a microword shows up while that word is current, as a wrong strobe or select in that same cycle. The stimulus mixes valid opcodes and random ones so that every table entry and the miss path to address 0 are taken many times.

// File: rtl/useq_pkg.sv
// Shared definitions for the microprogrammed control sequencer.
// Assumes a 4-bit microaddress and a 6-bit opcode; field codes are local choices.
package useq_pkg;

    parameter int UADDR_W = 4;
    parameter int OPC_W   = 6;

    // Sequencing field codes
    typedef enum logic [1:0] {
        SEQ_FETCH = 2'b00,
        SEQ_DISP1 = 2'b01,
        SEQ_DISP2 = 2'b10,
        SEQ_NEXT  = 2'b11
    } seq_e;

    // ALU field codes
    typedef enum logic [1:0] {
        ALU_ADD  = 2'b00,
        ALU_SUB  = 2'b01,
        ALU_FUNC = 2'b10,
        ALU_RSV  = 2'b11
    } alu_e;

    // Second operand field codes
    typedef enum logic [1:0] {
        OPB_REG   = 2'b00,
        OPB_FOUR  = 2'b01,
        OPB_EXT   = 2'b10,
        OPB_EXTSH = 2'b11
    } opb_e;

    // Register-file field codes
    typedef enum logic [1:0] {
        RFC_NONE  = 2'b00,
        RFC_READ  = 2'b01,
        RFC_W_ALU = 2'b10,
        RFC_W_MDR = 2'b11
    } rfc_e;

    // Memory field codes
    typedef enum logic [1:0] {
        MEM_NONE  = 2'b00,
        MEM_R_PC  = 2'b01,
        MEM_R_ALU = 2'b10,
        MEM_W_ALU = 2'b11
    } mem_e;

    // PC-update field codes
    typedef enum logic [1:0] {
        PCU_NONE = 2'b00,
        PCU_ALU  = 2'b01,
        PCU_COND = 2'b10,
        PCU_JUMP = 2'b11
    } pcu_e;

    typedef struct packed {
        alu_e alu;
        logic opa;   // 0: PC, 1: register A
        opb_e opb;
        rfc_e rfc;
        mem_e mem;
        pcu_e pcu;
        seq_e seq;
    } uword_t;

    // Microaddresses of the routines
    localparam logic [UADDR_W-1:0] UA_FETCH  = 4'd0;
    localparam logic [UADDR_W-1:0] UA_DECODE = 4'd1;
    localparam logic [UADDR_W-1:0] UA_MADDR  = 4'd2;
    localparam logic [UADDR_W-1:0] UA_LDRD   = 4'd3;
    localparam logic [UADDR_W-1:0] UA_LDWB   = 4'd4;
    localparam logic [UADDR_W-1:0] UA_STWR   = 4'd5;
    localparam logic [UADDR_W-1:0] UA_REXE   = 4'd6;
    localparam logic [UADDR_W-1:0] UA_RWB    = 4'd7;
    localparam logic [UADDR_W-1:0] UA_BRCMP  = 4'd8;
    localparam logic [UADDR_W-1:0] UA_JMP    = 4'd9;

    // Opcodes that the dispatch tables recognise
    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;

endpackage

// File: rtl/useq_store.sv
// Microcode store: returns the microword held at a microaddress.
// Assumes unused addresses hold an all-zero word, which means fetch with no action.
module useq_store
    import useq_pkg::*;
(
    input  logic [UADDR_W-1:0] addr,
    output uword_t             word
);

    // Builds one microword from its fields
    function automatic uword_t mk(alu_e a, logic s1, opb_e s2, rfc_e r,
                                  mem_e m, pcu_e p, seq_e q);
        uword_t w;
        w.alu = a; w.opa = s1; w.opb = s2; w.rfc = r;
        w.mem = m; w.pcu = p;  w.seq = q;
        return w;
    endfunction

    // Microprogram contents, one word per routine step
    always_comb begin
        unique case (addr)
            UA_FETCH:  word = mk(ALU_ADD,  1'b0, OPB_FOUR,  RFC_NONE,  MEM_R_PC,  PCU_ALU,  SEQ_NEXT);
            UA_DECODE: word = mk(ALU_ADD,  1'b0, OPB_EXTSH, RFC_READ,  MEM_NONE,  PCU_NONE, SEQ_DISP1);
            UA_MADDR:  word = mk(ALU_ADD,  1'b1, OPB_EXT,   RFC_NONE,  MEM_NONE,  PCU_NONE, SEQ_DISP2);
            UA_LDRD:   word = mk(ALU_ADD,  1'b0, OPB_REG,   RFC_NONE,  MEM_R_ALU, PCU_NONE, SEQ_NEXT);
            UA_LDWB:   word = mk(ALU_ADD,  1'b0, OPB_REG,   RFC_W_MDR, MEM_NONE,  PCU_NONE, SEQ_FETCH);
            UA_STWR:   word = mk(ALU_ADD,  1'b0, OPB_REG,   RFC_NONE,  MEM_W_ALU, PCU_NONE, SEQ_FETCH);
            UA_REXE:   word = mk(ALU_FUNC, 1'b1, OPB_REG,   RFC_NONE,  MEM_NONE,  PCU_NONE, SEQ_NEXT);
            UA_RWB:    word = mk(ALU_ADD,  1'b0, OPB_REG,   RFC_W_ALU, MEM_NONE,  PCU_NONE, SEQ_FETCH);
            UA_BRCMP:  word = mk(ALU_SUB,  1'b1, OPB_REG,   RFC_NONE,  MEM_NONE,  PCU_COND, SEQ_FETCH);
            UA_JMP:    word = mk(ALU_ADD,  1'b0, OPB_REG,   RFC_NONE,  MEM_NONE,  PCU_JUMP, SEQ_FETCH);
            default:   word = '0;
        endcase
    end

endmodule

// File: rtl/useq_dispatch.sv
// Dispatch tables: map the opcode to the target microaddress for each dispatch point.
// Assumes an unlisted opcode targets the fetch word (R3, R4).
module useq_dispatch
    import useq_pkg::*;
(
    input  logic [OPC_W-1:0]   opcode,
    output logic [UADDR_W-1:0] tgt_class,
    output logic [UADDR_W-1:0] tgt_mem
);

    // First table: instruction class routine (R3)
    always_comb begin
        unique case (opcode)
            OPC_RTYPE: tgt_class = UA_REXE;
            OPC_JUMP:  tgt_class = UA_JMP;
            OPC_BEQ:   tgt_class = UA_BRCMP;
            OPC_LOAD:  tgt_class = UA_MADDR;
            OPC_STORE: tgt_class = UA_MADDR;
            default:   tgt_class = UA_FETCH;
        endcase
    end

    // Second table: load or store continuation (R4)
    always_comb begin
        unique case (opcode)
            OPC_LOAD:  tgt_mem = UA_LDRD;
            OPC_STORE: tgt_mem = UA_STWR;
            default:   tgt_mem = UA_FETCH;
        endcase
    end

endmodule

// File: rtl/useq_decode.sv
// Field decoder: expands the encoded microword fields into datapath control lines.
// Assumes fields that a word does not use decode to all-zero lines.
module useq_decode
    import useq_pkg::*;
(
    input  uword_t     word,
    output logic       pc_load,
    output logic       pc_load_if_zero,
    output logic       addr_from_alu,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic       instr_load,
    output logic       wb_from_mem,
    output logic [1:0] pc_sel,
    output logic [1:0] alu_fn,
    output logic [1:0] alu_b_sel,
    output logic       alu_a_sel,
    output logic       rf_we,
    output logic       rf_dst_rd
);

    // ALU and operand selects pass straight through
    always_comb begin
        alu_fn    = (word.alu == ALU_RSV) ? 2'b00 : 2'(word.alu);
        alu_a_sel = word.opa;
        alu_b_sel = 2'(word.opb);
    end

    // Memory field to strobes and address source
    always_comb begin
        mem_rd = 1'b0; mem_wr = 1'b0; instr_load = 1'b0; addr_from_alu = 1'b0;
        unique case (word.mem)
            MEM_R_PC:  begin mem_rd = 1'b1; instr_load = 1'b1; end
            MEM_R_ALU: begin mem_rd = 1'b1; addr_from_alu = 1'b1; end
            MEM_W_ALU: begin mem_wr = 1'b1; addr_from_alu = 1'b1; end
            default:   ;
        endcase
    end

    // Register-file field to write enable and steering
    always_comb begin
        rf_we = 1'b0; rf_dst_rd = 1'b0; wb_from_mem = 1'b0;
        unique case (word.rfc)
            RFC_W_ALU: begin rf_we = 1'b1; rf_dst_rd = 1'b1; end
            RFC_W_MDR: begin rf_we = 1'b1; wb_from_mem = 1'b1; end
            default:   ;
        endcase
    end

    // PC-update field to PC write enables and source select
    always_comb begin
        pc_load = 1'b0; pc_load_if_zero = 1'b0; pc_sel = 2'b00;
        unique case (word.pcu)
            PCU_ALU:  pc_load = 1'b1;
            PCU_COND: begin pc_load_if_zero = 1'b1; pc_sel = 2'b01; end
            PCU_JUMP: begin pc_load = 1'b1; pc_sel = 2'b10; end
            default:  ;
        endcase
    end

endmodule

// File: rtl/useq_ctrl.sv
// Microprogrammed control sequencer top: microPC, address-select mux, store and decoder.
// Assumes a synchronous active-low reset; control lines depend only on the microPC.
module useq_ctrl
    import useq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OPC_W-1:0]   opcode,
    output logic               pc_load,
    output logic               pc_load_if_zero,
    output logic               addr_from_alu,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic               instr_load,
    output logic               wb_from_mem,
    output logic [1:0]         pc_sel,
    output logic [1:0]         alu_fn,
    output logic [1:0]         alu_b_sel,
    output logic               alu_a_sel,
    output logic               rf_we,
    output logic               rf_dst_rd,
    output logic [UADDR_W-1:0] uaddr
);

    localparam logic [UADDR_W-1:0] UA_ONE = UADDR_W'(1);

    logic [UADDR_W-1:0] upc, upc_nxt, tgt_class, tgt_mem;
    uword_t             word;

    useq_store u_store (.addr(upc), .word(word));

    useq_dispatch u_disp (.opcode(opcode), .tgt_class(tgt_class), .tgt_mem(tgt_mem));

    useq_decode u_dec (
        .word(word), .pc_load(pc_load), .pc_load_if_zero(pc_load_if_zero),
        .addr_from_alu(addr_from_alu), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .instr_load(instr_load), .wb_from_mem(wb_from_mem), .pc_sel(pc_sel),
        .alu_fn(alu_fn), .alu_b_sel(alu_b_sel), .alu_a_sel(alu_a_sel),
        .rf_we(rf_we), .rf_dst_rd(rf_dst_rd)
    );

    // Four-way address select driven by the sequencing field
    always_comb begin
        unique case (word.seq)
            SEQ_NEXT:  upc_nxt = upc + UA_ONE;
            SEQ_DISP1: upc_nxt = tgt_class;
            SEQ_DISP2: upc_nxt = tgt_mem;
            default:   upc_nxt = UA_FETCH;
        endcase
    end

    // MicroPC register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) upc <= UA_FETCH;
        else        upc <= upc_nxt;
    end

    assign uaddr = upc;

    // R1: reset forces the fetch address
    a_r1_reset_to_fetch: assert property (@(posedge clk) !rst_n |=> (uaddr == UA_FETCH));

    // R2: fetch word is followed by the decode word
    a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr == UA_FETCH) |=> (uaddr == UA_DECODE));

    // R4: second dispatch lands on load read, store write or fetch
    a_r4_disp2_targets: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr == UA_MADDR) |=> (uaddr == UA_LDRD || uaddr == UA_STWR || uaddr == UA_FETCH));

    // R5: terminal words return to fetch
    a_r5_terminal_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr == UA_LDWB || uaddr == UA_STWR || uaddr == UA_RWB ||
         uaddr == UA_BRCMP || uaddr == UA_JMP) |=> (uaddr == UA_FETCH));

    // R9: memory read and write never coincide
    a_r9_mem_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R6: instruction register loads only in the fetch word
    a_r6_ir_only_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        instr_load |-> (uaddr == UA_FETCH));

    // R13: at most one PC write enable at a time
    a_r13_pc_enables: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pc_load, pc_load_if_zero}));

endmodule

// File: tb/useq_ctrl_test.sv
// Bench for the sequencer: random opcodes mixed with directed resets, checked against a
// bench-side address model and an expected control-line table.
module useq_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'd0;
    logic       pc_load, pc_load_if_zero, addr_from_alu, mem_rd, mem_wr, instr_load;
    logic       wb_from_mem, alu_a_sel, rf_we, rf_dst_rd;
    logic [1:0] pc_sel, alu_fn, alu_b_sel;
    logic [3:0] uaddr;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    useq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode),
        .pc_load(pc_load), .pc_load_if_zero(pc_load_if_zero), .addr_from_alu(addr_from_alu),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .instr_load(instr_load), .wb_from_mem(wb_from_mem),
        .pc_sel(pc_sel), .alu_fn(alu_fn), .alu_b_sel(alu_b_sel), .alu_a_sel(alu_a_sel),
        .rf_we(rf_we), .rf_dst_rd(rf_dst_rd), .uaddr(uaddr)
    );

    // Order: pc_load, pc_load_if_zero, addr_from_alu, mem_rd, mem_wr, instr_load,
    //        wb_from_mem, pc_sel[2], alu_fn[2], alu_b_sel[2], alu_a_sel, rf_we, rf_dst_rd
    function automatic logic [15:0] exp_ctrl(input logic [3:0] a);
        case (a)
            4'd0: return 16'b1_0_0_1_0_1_0_00_00_01_0_0_0;
            4'd1: return 16'b0_0_0_0_0_0_0_00_00_11_0_0_0;
            4'd2: return 16'b0_0_0_0_0_0_0_00_00_10_1_0_0;
            4'd3: return 16'b0_0_1_1_0_0_0_00_00_00_0_0_0;
            4'd4: return 16'b0_0_0_0_0_0_1_00_00_00_0_1_0;
            4'd5: return 16'b0_0_1_0_1_0_0_00_00_00_0_0_0;
            4'd6: return 16'b0_0_0_0_0_0_0_00_10_00_1_0_0;
            4'd7: return 16'b0_0_0_0_0_0_0_00_00_00_0_1_1;
            4'd8: return 16'b0_1_0_0_0_0_0_01_01_00_1_0_0;
            4'd9: return 16'b1_0_0_0_0_0_0_10_00_00_0_0_0;
            default: return 16'd0;
        endcase
    endfunction

    function automatic string out_tag(input logic [3:0] a);
        case (a)
            4'd0: return "R6";
            4'd1: return "R7";
            4'd2: return "R8";
            4'd3, 4'd5: return "R9";
            4'd4, 4'd7: return "R10";
            4'd6: return "R11";
            4'd8, 4'd9: return "R12";
            default: return "R13";
        endcase
    endfunction

    function automatic logic [3:0] exp_next(input logic [3:0] a, input logic [5:0] op);
        case (a)
            4'd0, 4'd3, 4'd6: return a + 4'd1;
            4'd1: case (op)
                6'b000000: return 4'd6;
                6'b000010: return 4'd9;
                6'b000100: return 4'd8;
                6'b100011, 6'b101011: return 4'd2;
                default: return 4'd0;
            endcase
            4'd2: case (op)
                6'b100011: return 4'd3;
                6'b101011: return 4'd5;
                default: return 4'd0;
            endcase
            default: return 4'd0;
        endcase
    endfunction

    function automatic string next_tag(input logic [3:0] a);
        case (a)
            4'd0, 4'd3, 4'd6: return "R2";
            4'd1: return "R3";
            4'd2: return "R4";
            default: return "R5";
        endcase
    endfunction

    function automatic logic [5:0] pick_opcode();
        logic [5:0] pool [5] = '{6'b000000, 6'b000010, 6'b000100, 6'b100011, 6'b101011};
        if ($urandom_range(3) == 0) return 6'($urandom);
        return pool[$urandom_range(4)];
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic [15:0] ctl;
    assign ctl = {pc_load, pc_load_if_zero, addr_from_alu, mem_rd, mem_wr, instr_load,
                  wb_from_mem, pc_sel, alu_fn, alu_b_sel, alu_a_sel, rf_we, rf_dst_rd};

    // Watchdog: a hung run counts as a failure
    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [3:0] model;
        logic [3:0] prev;
        void'($urandom(32'h1234_5eed));
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset uaddr", {12'd0, uaddr}, 16'd0);
        check("R6 outputs in reset", ctl, exp_ctrl(4'd0));
        rst_n = 1'b1;
        model = 4'd0;
        // Directed: every table entry and misses, then random traffic
        for (int i = 0; i < 6000; i++) begin
            if (i > 0 && (i % 997) == 0) begin
                rst_n = 1'b0;                 // R1: reset in mid-routine
                opcode = pick_opcode();
                @(posedge clk);
                @(negedge clk);
                check("R1 mid-run reset", {12'd0, uaddr}, 16'd0);
                rst_n = 1'b1;
                model = 4'd0;
            end
            check(out_tag(model), ctl, exp_ctrl(model));
            opcode = pick_opcode();
            prev = model;
            model = exp_next(model, opcode);
            @(posedge clk);
            @(negedge clk);
            check(next_tag(prev), {12'd0, uaddr}, {12'd0, model});
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule